// File: doc/BRIEF.md
# Binary-Weighted Bit-Plane Sequencer

This block drives an array of pixels that can only be fully on or fully off. It does so by showing a colour frame one bit-plane at a time. A 24-bit frame is held in an external frame store as 24 single-bit planes. The sequencer fetches each plane in turn and presents it to the array. It keeps each plane on screen for a time that is proportional to the plane's binary weight. The perceived intensity of each pixel is therefore the sum of the weighted times during which that pixel is lit.

Two modes exist. In video mode all 24 planes are shown: the eight red planes first, then the eight green planes, then the eight blue planes. Within each colour the planes run from least to most significant. In pattern mode the planes are grouped into patterns of N consecutive planes, where N is the bit depth. The planes inside a pattern are weighted 1, 2, 4 and so on, and a camera trigger pulse marks the first plane of every pattern. A programmable base time unit scales every hold time. The mode, the bit depth and the base unit take effect only at frame boundaries.

Top module: `bitplane_seq`

## Requirements
- R1: In video mode each frame presents planes 0 to 23 in ascending order, with red bits 0-7 at indices 0-7, green at 8-15 and blue at 16-23. After plane 23 the next frame starts again at plane 0.
- R2: Plane index p is shown with weight w = p mod N, where N is 8 in video mode. The plane is held for base × 2^w cycles, measured from its plane_valid pulse to the next plane_valid pulse.
- R3: In pattern mode the depth N is clamped: a setting of 0 becomes 1, and any setting above 8 becomes 8. Each frame then shows planes 0 to floor(24/N)×N−1 in ascending order.
- R4: In pattern mode, trigger pulses for one cycle together with plane_valid whenever the plane index is a multiple of N. Trigger never goes high in video mode, and never goes high without plane_valid.
- R5: frame_done pulses for one cycle in the cycle that the last plane's hold time ends. That is the same cycle as the plane_valid of plane 0 of the next frame. It does not pulse at the start of the first frame after reset.
- R6: Mode, bit depth and base unit are sampled only when a frame begins. Changes made during a frame do not alter that frame.
- R7: For every plane, rd_en is high for one cycle with rd_addr equal to the plane index. rd_data is taken one cycle later. plane_data shows that word from the plane's plane_valid pulse until the next plane_valid pulse, and plane_valid follows rd_en by exactly two cycles.
- R8: A base unit of 0 is treated as 1.
- R9: While reset is held, plane_valid, trigger and frame_done are low. The first plane_valid (plane 0) appears after the third rising edge with reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pattern_mode | input | 1 | 1 selects pattern mode, 0 selects video mode |
| bit_depth | input | 4 | Planes per pattern in pattern mode (clamped to 1..8) |
| base_unit | input | BASE_W | Cycles per unit of plane weight (0 acts as 1) |
| rd_en | output | 1 | Frame-store read strobe, one cycle per plane |
| rd_addr | output | 5 | Plane index being read |
| rd_data | input | PLANE_W | Plane word, returned one cycle after rd_en |
| plane_valid | output | 1 | One-cycle strobe when a new plane is presented |
| plane_idx | output | 5 | Index of the plane being shown |
| plane_data | output | PLANE_W | Plane word being shown |
| trigger | output | 1 | Camera trigger at the start of each pattern |
| frame_done | output | 1 | Pulse when a frame's last plane has finished |

## Verification
The bench targets the following corner cases.

- **Hold lengths of one cycle** (base 1, depth 1). Valid strobes then arrive back to back, and a timer that reloads late would insert idle cycles and stretch every gap.
- **Depth settings that do not divide 24** (5 and 7). A sequencer that did not trim the frame would show an extra partial pattern, with a trigger that is never followed by a full pattern.
- **Depth settings 0 and 12, and a base unit of 0.** Here a missing clamp would stall the sequence or fall outside the 1-to-8 range.
- **Settings changed twice inside a running frame.** A design that sampled them at any time other than the frame boundary would show wrong hold times, or a wrong slot count, in the frame that is already under way.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int NUM_PLANES = 24;
  localparam int CH_BITS    = 8;
  localparam int IDX_W      = $clog2(NUM_PLANES);
  localparam int SHIFT_MAX  = $clog2(CH_BITS);

  typedef struct packed {
    logic       pat;
    logic [3:0] n;
  } frame_cfg_t;

  // Planes per weight group: 8 in video mode, clamped depth in pattern mode
  function automatic logic [3:0] eff_depth(input logic pat, input logic [3:0] d);
    if (!pat)                      return 4'(CH_BITS);
    else if (d == 4'd0)            return 4'd1;
    else if (d > 4'(CH_BITS))      return 4'(CH_BITS);
    else                           return d;
  endfunction

  // Slots in one frame: whole groups only
  function automatic logic [IDX_W:0] slots_per_frame(input logic [3:0] n);
    int groups;
    groups = NUM_PLANES / int'(n);
    return (IDX_W+1)'(groups * int'(n));
  endfunction

  // Binary weight exponent of a slot
  function automatic logic [SHIFT_MAX-1:0] slot_weight(input logic [IDX_W-1:0] s,
                                                       input logic [3:0] n);
    return SHIFT_MAX'(int'(s) % int'(n));
  endfunction
endpackage

// File: rtl/bps_cfg_latch.sv
module bps_cfg_latch
  import bps_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pat_i,
  input  logic [3:0]        depth_i,
  input  logic [BASE_W-1:0] base_i,
  output frame_cfg_t        cfg_o,
  output logic [BASE_W-1:0] base_o
);
  frame_cfg_t        live_cfg, held_cfg;
  logic [BASE_W-1:0] live_base, held_base;

  always_comb begin
    live_cfg.pat = pat_i;
    live_cfg.n   = eff_depth(pat_i, depth_i);
    live_base    = (base_i == '0) ? BASE_W'(1) : base_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_cfg  <= '{pat: 1'b0, n: 4'(CH_BITS)};
      held_base <= BASE_W'(1);
    end else if (frame_start) begin
      held_cfg  <= live_cfg;
      held_base <= live_base;
    end
  end

  assign cfg_o  = frame_start ? live_cfg  : held_cfg;
  assign base_o = frame_start ? live_base : held_base;

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(held_cfg) && $stable(held_base)));
endmodule

// File: rtl/bps_slot_timer.sv
module bps_slot_timer
  import bps_pkg::*;
#(
  parameter int BASE_W = 8,
  localparam int CNT_W = BASE_W + CH_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BASE_W-1:0]    base_i,
  input  logic [SHIFT_MAX-1:0] weight_i,
  output logic                 slot_start_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hold_now;

  function automatic logic [CNT_W-1:0] hold_len(input logic [BASE_W-1:0] b,
                                                input logic [SHIFT_MAX-1:0] w);
    return CNT_W'(b) << w;
  endfunction

  assign hold_now     = hold_len(base_i, weight_i);
  assign slot_start_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (slot_start_o)      cnt_q <= hold_now - CNT_W'(1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R2
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start_o && hold_now != CNT_W'(1)) |=> !slot_start_o);
endmodule

// File: rtl/bps_plane_out.sv
module bps_plane_out
  import bps_pkg::*;
#(
  parameter int PLANE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic [IDX_W-1:0]   s1_idx,
  input  logic               s1_trig,
  input  logic               s1_done,
  input  logic [PLANE_W-1:0] rd_data,
  output logic               plane_valid,
  output logic [IDX_W-1:0]   plane_idx,
  output logic [PLANE_W-1:0] plane_data,
  output logic               trigger,
  output logic               frame_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plane_valid <= 1'b0;
      plane_idx   <= '0;
      plane_data  <= '0;
      trigger     <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      plane_valid <= s1_valid;
      trigger     <= s1_valid && s1_trig;
      frame_done  <= s1_valid && s1_done;
      if (s1_valid) begin
        plane_idx  <= s1_idx;
        plane_data <= rd_data;
      end
    end
  end

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plane_idx < IDX_W'(NUM_PLANES));
endmodule

// File: rtl/bitplane_seq.sv
module bitplane_seq
  import bps_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int PLANE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pattern_mode,
  input  logic [3:0]         bit_depth,
  input  logic [BASE_W-1:0]  base_unit,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_addr,
  input  logic [PLANE_W-1:0] rd_data,
  output logic               plane_valid,
  output logic [IDX_W-1:0]   plane_idx,
  output logic [PLANE_W-1:0] plane_data,
  output logic               trigger,
  output logic               frame_done
);
  // Named internal events
  logic                 slot_start;
  logic                 frame_start;
  logic                 last_slot;
  frame_cfg_t           cfg;
  logic [BASE_W-1:0]    base_eff;
  logic [IDX_W:0]       slot_cnt;
  logic [SHIFT_MAX-1:0] weight;

  logic [IDX_W-1:0] slot_q;
  logic             wrapped_q;
  logic             s1_valid, s1_trig, s1_done;
  logic [IDX_W-1:0] s1_idx;

  assign frame_start = slot_start && (slot_q == '0);
  assign slot_cnt    = slots_per_frame(cfg.n);
  assign weight      = slot_weight(slot_q, cfg.n);
  assign last_slot   = ({1'b0, slot_q} == slot_cnt - (IDX_W+1)'(1));

  bps_cfg_latch #(.BASE_W(BASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pat_i(pattern_mode), .depth_i(bit_depth), .base_i(base_unit),
    .cfg_o(cfg), .base_o(base_eff)
  );

  bps_slot_timer #(.BASE_W(BASE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .base_i(base_eff), .weight_i(weight),
    .slot_start_o(slot_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q    <= '0;
      wrapped_q <= 1'b0;
    end else if (slot_start) begin
      slot_q    <= last_slot ? '0 : slot_q + IDX_W'(1);
      wrapped_q <= last_slot;
    end
  end

  assign rd_en   = slot_start;
  assign rd_addr = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s1_trig  <= 1'b0;
      s1_done  <= 1'b0;
    end else begin
      s1_valid <= slot_start;
      s1_idx   <= slot_q;
      s1_trig  <= cfg.pat && (weight == '0);
      s1_done  <= wrapped_q;
    end
  end

  bps_plane_out #(.PLANE_W(PLANE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_idx(s1_idx),
    .s1_trig(s1_trig), .s1_done(s1_done), .rd_data(rd_data),
    .plane_valid(plane_valid), .plane_idx(plane_idx), .plane_data(plane_data),
    .trigger(trigger), .frame_done(frame_done)
  );

  // R7
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ##2 plane_valid);
  // R5
  done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (plane_valid && plane_idx == '0));
  // R4
  trig_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> plane_valid);
  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, slot_q} < slot_cnt);
endmodule

// File: tb/bitplane_seq_test.sv
module bitplane_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_W     = 8;
  localparam int PLANE_W    = 16;
  localparam int NUM_FRAMES = 14;
  localparam int WATCHDOG   = 150000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               pattern_mode;
  logic [3:0]         bit_depth;
  logic [BASE_W-1:0]  base_unit;
  logic               rd_en;
  logic [4:0]         rd_addr;
  logic [PLANE_W-1:0] rd_data;
  logic               plane_valid;
  logic [4:0]         plane_idx;
  logic [PLANE_W-1:0] plane_data;
  logic               trigger;
  logic               frame_done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitplane_seq #(.BASE_W(BASE_W), .PLANE_W(PLANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .pattern_mode(pattern_mode), .bit_depth(bit_depth),
    .base_unit(base_unit), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .plane_valid(plane_valid), .plane_idx(plane_idx), .plane_data(plane_data),
    .trigger(trigger), .frame_done(frame_done)
  );

  function automatic logic [PLANE_W-1:0] word_of(input int a);
    logic [4:0] x;
    x = 5'(a);
    return {x, ~x, x + 5'd7, 1'b1};
  endfunction

  // Frame store model: one-cycle read latency
  always @(posedge clk) rd_data <= rd_en ? word_of(int'(rd_addr)) : '0;

  function automatic int group_of(input bit pat, input int d);
    if (!pat) return 8;
    if (d == 0) return 1;
    if (d > 8) return 8;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model state: pending settings (next frame) and current-frame settings
  bit p_pat, c_pat;
  int p_n, p_base, c_n, c_base;

  task automatic drive(input bit pat, input int d, input int b);
    pattern_mode = pat;
    bit_depth    = 4'(d);
    base_unit    = BASE_W'(b);
  endtask

  task automatic plan_frame(input int k);
    bit pat; int d, b;
    case (k)
      1: begin pat = 1; d = 1;  b = 1; end
      2: begin pat = 1; d = 0;  b = 2; end
      3: begin pat = 1; d = 12; b = 0; end
      4: begin pat = 1; d = 5;  b = 1; end
      5: begin pat = 1; d = 7;  b = 3; end
      6: begin pat = 0; d = 3;  b = 0; end
      default: begin pat = 1'($urandom % 2); d = int'($urandom % 11); b = int'($urandom % 4); end
    endcase
    drive(pat, d, b);
    p_pat = pat; p_n = group_of(pat, d); p_base = (b == 0) ? 1 : b;
  endtask

  initial begin
    int t, t_prev, prev_len, exp_idx, frames, cur_shown, w, cnt;
    bit seen, stop;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    drive(0, 0, 1);
    p_pat = 0; p_n = 8; p_base = 1;
    c_pat = 0; c_n = 8; c_base = 1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(plane_valid == 1'b0, "R9 plane_valid in reset", int'(plane_valid), 0);
    check(trigger == 1'b0, "R9 trigger in reset", int'(trigger), 0);
    check(frame_done == 1'b0, "R9 frame_done in reset", int'(frame_done), 0);
    rst_n = 1'b1;
    t = 0; t_prev = 0; prev_len = 0; exp_idx = 0; frames = 0;
    cur_shown = 0; seen = 0; stop = 0;
    while (!stop) begin
      @(negedge clk);
      t++;
      if (t > WATCHDOG) begin
        check(1'b0, "watchdog", t, WATCHDOG);
        stop = 1;
      end else if (plane_valid) begin
        check(int'(plane_idx) == exp_idx, "R1 R3 plane order", int'(plane_idx), exp_idx);
        if (!seen) check(t == 3, "R9 first plane latency", t, 3);
        else check(t - t_prev == prev_len, "R2 R6 R8 hold time", t - t_prev, prev_len);
        if (exp_idx == 0) begin
          c_pat = p_pat; c_n = p_n; c_base = p_base;
          frames++;
          // decoy write mid-frame, overwritten before the boundary
          drive(1'($urandom % 2), int'($urandom % 16), int'($urandom % 256));
          check(frame_done == seen, "R5 frame_done at boundary", int'(frame_done), int'(seen));
        end else begin
          check(frame_done == 1'b0, "R5 frame_done mid-frame", int'(frame_done), 0);
        end
        if (exp_idx == 3) plan_frame(frames);
        w = exp_idx % c_n;
        check(trigger == (c_pat && w == 0), "R4 trigger", int'(trigger), int'(c_pat && w == 0));
        prev_len = c_base * (1 << w);
        t_prev = t;
        cur_shown = exp_idx;
        seen = 1;
        cnt = (24 / c_n) * c_n;
        exp_idx = (exp_idx + 1 == cnt) ? 0 : exp_idx + 1;
        if (frames > NUM_FRAMES) stop = 1;
      end else begin
        if (trigger) check(1'b0, "R4 trigger without valid", 1, 0);
        if (frame_done) check(1'b0, "R5 frame_done without valid", 1, 0);
        if (seen && t - t_prev >= prev_len)
          check(1'b0, "R2 plane held too long", t - t_prev, prev_len);
      end
      if (seen && !stop)
        check(plane_data == word_of(cur_shown), "R7 plane_data",
              int'(plane_data), int'(word_of(cur_shown)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule